// File: doc/BRIEF.md
# Unaligned Multi-Byte Signature Matcher

The block scans a packet payload stream, four bytes per clock, for a fixed set of byte signatures. The signatures are chosen when the design is built, through parameters. Byte comparators decode every input lane against each character that any signature needs. A chain of processing elements then carries partial-match state from one lane to the next, and from the last lane of one word into the first lane of the next word. As a result, a signature may begin in any lane, may cross word boundaries, and may be longer than the four-byte input word. No key memory is stored. To change the signatures, the design must be rebuilt.

Lane 0 (`data_i[7:0]`) is the earliest byte of a word in stream order, and lane 3 (`data_i[31:24]`) is the latest. A word counts only when `valid_i` is high. `byte_en_i` marks which lanes carry payload. `last_i` marks the final word of a packet, and all partial-match state is cleared after that word. The per-signature match vector is combinational, so it reports a hit in the same cycle as the word that carries the signature's final byte. A registered alert pulse toward the host follows one cycle later.

Top module: `sig_matcher_top`

## Requirements
- R1: A signature that lies entirely within one valid word is reported whatever lane it starts in.
- R2: A signature whose bytes straddle two consecutive valid words is reported. For example, "f","l" in lanes 2 and 3, followed by "4","4" in lanes 0 and 1, reports "l44".
- R3: A signature longer than four bytes is reported when its bytes span three consecutive valid words.
- R4: Bit s of `match_o` is high only in a cycle where `valid_i` is high and that word holds the final byte of signature s.
- R5: A lane whose `byte_en_i` bit is 0 never completes a match, and it breaks any partial match that passes through it. A valid word with `byte_en_i` = 0 reports no match.
- R6: Cycles with `valid_i` low leave the partial-match state unchanged. Idle gaps between words therefore do not break a match.
- R7: After a word with `valid_i` and `last_i` both high, all partial-match state is cleared, so a signature split across two packets is not reported. A match completed inside the last word itself is still reported.
- R8: `alert_o` is high in the cycle after any bit of `match_o` is high, and low in the cycle after `match_o` is all zero.
- R9: While `rst_ni` is low, and right after it is released, `match_o` and `alert_o` are zero and no partial match is held.
- R10: Every signature whose final byte appears in a word is reported in that word. This includes several signatures at once and overlapping occurrences of the same signature ("aaa" against "aa").

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is present |
| last_i | input | 1 | Word is the final word of its packet |
| data_i | input | 32 | Payload bytes; lane 0 in bits 7:0 is the earliest |
| byte_en_i | input | 4 | Per-lane payload enable |
| match_o | output | NUM_SIG (3) | Per-signature match in the word carrying the final byte |
| alert_o | output | 1 | Registered alert pulse, one cycle after any match |

## Verification
The assertions assume that `valid_i`, `last_i` and `byte_en_i` are known (not X or Z) at every rising edge after reset. They also assume that these inputs change only between edges, so that the held-state and clear-on-last properties compare whole words. The bench meets this by driving every input on the falling edge, and by keeping `valid_i` at zero until reset has been released. The bench reference model follows the same word rules: lanes are consumed in order, disabled lanes restart matching, and `last_i` ends the packet. It is run against directed cases and against a long pseudo-random stream over a small alphabet built from the signatures' own characters.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sm_byte_cmp.sv
module sm_byte_cmp #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned NUM_SIG = 3,
  parameter int unsigned MAX_LEN = 6,
  parameter logic [NUM_SIG*MAX_LEN*8-1:0] SIG_DATA = '0,
  parameter logic [NUM_SIG*8-1:0]         SIG_LEN  = '0
) (
  input  logic [LANES*8-1:0]               data_i,
  input  logic [LANES-1:0]                 en_i,
  output logic [LANES*NUM_SIG*MAX_LEN-1:0] hit_o
);
  import sm_pkg::*;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    byte_t lane_b;
    assign lane_b = data_i[l*8 +: 8];
    for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
      for (genvar k = 0; k < MAX_LEN; k++) begin : g_pos
        localparam byte_t CH = SIG_DATA[(s*MAX_LEN+k)*8 +: 8];
        if (k < int'(SIG_LEN[s*8 +: 8])) begin : g_used
          assign hit_o[(l*NUM_SIG+s)*MAX_LEN+k] = en_i[l] & (lane_b == CH);
        end else begin : g_unused
          assign hit_o[(l*NUM_SIG+s)*MAX_LEN+k] = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sm_pe_chain.sv
module sm_pe_chain #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned MAX_LEN = 6,
  parameter int unsigned LEN     = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     last_i,
  input  logic [LANES-1:0]         en_i,
  input  logic [LANES*MAX_LEN-1:0] hit_i,
  output logic                     match_o
);
  // bit k of a stage: first k+1 signature bytes matched, ending at that lane
  logic [LANES:0][MAX_LEN-1:0] stage;
  logic [MAX_LEN-1:0]          part_q;
  logic [LANES-1:0]            lane_hit;

  always_comb begin
    stage[0] = part_q;
    for (int l = 0; l < LANES; l++) begin
      stage[l+1][0] = hit_i[l*MAX_LEN];
      for (int k = 1; k < MAX_LEN; k++)
        stage[l+1][k] = stage[l][k-1] & hit_i[l*MAX_LEN+k];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_done
    assign lane_hit[l] = stage[l+1][LEN-1];
  end

  assign match_o = valid_i & (|lane_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                part_q <= '0;
    else if (valid_i && last_i) part_q <= '0;
    else if (valid_i)           part_q <= stage[LANES];
  end

  assert_clear_on_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> (part_q == '0));
  assert_hold_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(part_q));
  assert_match_needs_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !match_o);
  assert_masked_word_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && en_i == '0) |-> !match_o);
endmodule

// File: rtl/sm_alert.sv
module sm_alert #(
  parameter int unsigned NUM_SIG = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SIG-1:0] match_i,
  output logic               alert_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_o <= 1'b0;
    else         alert_o <= |match_i;
  end
endmodule

// File: rtl/sig_matcher_top.sv
module sig_matcher_top #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned NUM_SIG = 3,
  parameter int unsigned MAX_LEN = 6,
  // byte k of signature s sits at bits (s*MAX_LEN+k)*8; defaults "l44", "attack", "aa"
  parameter logic [NUM_SIG*MAX_LEN*8-1:0] SIG_DATA =
    {48'h0000_0000_6161, 48'h6B63_6174_7461, 48'h0000_0034_346C},
  parameter logic [NUM_SIG*8-1:0] SIG_LEN = {8'd2, 8'd6, 8'd3}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               last_i,
  input  logic [LANES*8-1:0] data_i,
  input  logic [LANES-1:0]   byte_en_i,
  output logic [NUM_SIG-1:0] match_o,
  output logic               alert_o
);
  localparam int unsigned HIT_W = LANES*NUM_SIG*MAX_LEN;

  logic [HIT_W-1:0]                         hit;
  logic [NUM_SIG-1:0][LANES*MAX_LEN-1:0]    sig_hit;

  sm_byte_cmp #(
    .LANES(LANES), .NUM_SIG(NUM_SIG), .MAX_LEN(MAX_LEN),
    .SIG_DATA(SIG_DATA), .SIG_LEN(SIG_LEN)
  ) u_cmp (
    .data_i(data_i), .en_i(byte_en_i), .hit_o(hit)
  );

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign sig_hit[s][l*MAX_LEN +: MAX_LEN] = hit[(l*NUM_SIG+s)*MAX_LEN +: MAX_LEN];
    end
    sm_pe_chain #(
      .LANES(LANES), .MAX_LEN(MAX_LEN), .LEN(int'(SIG_LEN[s*8 +: 8]))
    ) u_pe (
      .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .last_i(last_i),
      .en_i(byte_en_i), .hit_i(sig_hit[s]), .match_o(match_o[s])
    );
  end

  sm_alert #(.NUM_SIG(NUM_SIG)) u_alert (
    .clk_i(clk_i), .rst_ni(rst_ni), .match_i(match_o), .alert_o(alert_o)
  );

  assert_alert_after_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|match_o) |=> alert_o);
  assert_alert_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o == '0) |=> !alert_o);
endmodule

// File: tb/sim_sig_matcher_top.sv
`timescale 1ns/100ps
module sim_sig_matcher_top;
  localparam int NS = 3;
  localparam int ML = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, last_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [3:0]  byte_en_i = '0;
  logic [NS-1:0] match_o;
  logic        alert_o;

  int checks = 0, failures = 0;
  logic [7:0] sig_b [NS][ML];
  int         sig_l [NS];
  logic [7:0] hist [ML];
  int         hist_n = 0;
  logic       prev_any = 1'b0;
  logic [31:0] rng = 32'h1234_5678;
  bit         done = 0;

  always #2.5 clk = ~clk;

  sig_matcher_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .last_i(last_i),
    .data_i(data_i), .byte_en_i(byte_en_i), .match_o(match_o), .alert_o(alert_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] model_word(logic v, logic lst, logic [31:0] d, logic [3:0] m);
    logic [NS-1:0] r = '0;
    if (!v) return '0;
    for (int l = 0; l < 4; l++) begin
      if (m[l]) begin
        for (int j = ML-1; j > 0; j--) hist[j] = hist[j-1];
        hist[0] = d[l*8 +: 8];
        if (hist_n < ML) hist_n++;
        for (int s = 0; s < NS; s++) begin
          bit ok = (hist_n >= sig_l[s]);
          for (int k = 0; k < sig_l[s]; k++)
            if (ok && hist[sig_l[s]-1-k] != sig_b[s][k]) ok = 0;
          if (ok) r[s] = 1'b1;
        end
      end else hist_n = 0;
    end
    if (lst) hist_n = 0;
    return r;
  endfunction

  task automatic send(string tag, logic v, logic lst, logic [31:0] d, logic [3:0] m);
    logic [NS-1:0] exp;
    @(negedge clk);
    valid_i = v; last_i = lst; data_i = d; byte_en_i = m;
    #1;
    exp = model_word(v, lst, d, m);
    chk({tag, " match_o"}, 32'(match_o), 32'(exp));
    chk("R8 alert_o", 32'(alert_o), 32'(prev_any));
    prev_any = |exp;
  endtask

  // lane 0 is the lowest byte; string "abcd" packs lane0='a'
  function automatic logic [31:0] w(string s);
    logic [31:0] r = '0;
    for (int i = 0; i < 4 && i < s.len(); i++) r[i*8 +: 8] = s[i];
    return r;
  endfunction

  function automatic logic [31:0] nxt();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string alpha = "atcklf4x";
    sig_l[0] = 3; sig_l[1] = 6; sig_l[2] = 2;
    for (int s = 0; s < NS; s++) for (int k = 0; k < ML; k++) sig_b[s][k] = 8'h00;
    sig_b[0][0] = "l"; sig_b[0][1] = "4"; sig_b[0][2] = "4";
    sig_b[1][0] = "a"; sig_b[1][1] = "t"; sig_b[1][2] = "t";
    sig_b[1][3] = "a"; sig_b[1][4] = "c"; sig_b[1][5] = "k";
    sig_b[2][0] = "a"; sig_b[2][1] = "a";
    for (int j = 0; j < ML; j++) hist[j] = 8'h00;

    repeat (3) @(negedge clk);
    chk("R9 match_o in reset", 32'(match_o), 0);
    chk("R9 alert_o in reset", 32'(alert_o), 0);
    rst_ni = 1'b1;
    send("R9 after reset", 1, 1, w("44xx"), 4'hF);

    send("R1 lane0", 1, 1, w("l44x"), 4'hF);
    send("R1 lane1", 1, 1, w("xl44"), 4'hF);
    send("R2 first half", 1, 0, w("xxfl"), 4'hF);
    send("R2 fl44 straddle", 1, 1, w("44xx"), 4'hF);
    send("R3 word a", 1, 0, w("xxxa"), 4'hF);
    send("R3 word b", 1, 0, w("ttac"), 4'hF);
    send("R3 attack end", 1, 1, w("kxxx"), 4'hF);
    send("R5 masked lane", 1, 1, w("l4x4"), 4'b1011);
    send("R5 all masked", 1, 1, w("l44x"), 4'h0);
    send("R5 mask breaks span a", 1, 0, w("xxl4"), 4'b0111);
    send("R5 mask breaks span b", 1, 1, w("4xxx"), 4'hF);
    send("R6 before gap", 1, 0, w("xxl4"), 4'hF);
    send("R6 idle", 0, 0, w("l44l"), 4'hF);
    send("R6 after gap", 1, 1, w("4xxx"), 4'hF);
    send("R7 packet end", 1, 1, w("xxl4"), 4'hF);
    send("R7 new packet", 1, 1, w("4xxx"), 4'hF);
    send("R7 match in last", 1, 1, w("xl44"), 4'hF);
    send("R10 overlap aa", 1, 1, w("aaax"), 4'hF);
    send("R10 two sigs", 1, 0, w("aal4"), 4'hF);
    send("R10 two sigs b", 1, 1, w("4xxx"), 4'hF);

    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r = nxt();
      logic [31:0] d;
      for (int l = 0; l < 4; l++) d[l*8 +: 8] = alpha[r[l*3 +: 3]];
      send("R10 sweep", r[12 +: 3] != 0, r[16 +: 4] == 0,
           d, (r[20 +: 2] == 0) ? r[24 +: 4] : 4'hF);
    end
    send("R4 idle tail", 0, 0, w("l44l"), 4'hF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule